// File: doc/BRIEF.md
# Daylight Saving Hour Corrector

This block watches the time and calendar fields of a real-time clock at the moment of each once-per-second update. When daylight-saving correction is enabled, it recognises the two days of the year on which the hour must be adjusted. On the spring day the clock skips from 1:59:59 AM to 3:00:00 AM. On the autumn day the clock repeats the hour from 1:59:59 AM back to 1:00:00 AM.

For each update strobe that lands on a qualifying second, the block issues a one-cycle command: jump forward or fall back. With the command it gives the replacement hours byte, in the same data encoding and hour format that the time fields use. The clock's own carry logic uses that byte in place of its normal hour rollover. Inside the block, a one-shot guard makes sure the repeated hour is not corrected a second time.

Top module: `dst_adjuster`

## Requirements
- R1: A strobe arrives with the time at 1:59:59 AM, day-of-week 1 (Sunday), month 4 and date 1 to 7. On the next clock cycle `jump_fwd` pulses and `hour_out` carries hour 3 AM.
- R2: A strobe arrives with the time at 1:59:59 AM, day-of-week 1, month 10 and date 25 to 31. On the next cycle `fall_back` pulses and `hour_out` carries hour 1 AM.
- R3: After a fall-back, no further fall-back is issued while the day still qualifies. The guard re-arms on any cycle in which day-of-week, date or month no longer qualify.
- R4: With `bin_mode`=1 every field is plain binary. With `bin_mode`=0 every field is BCD, with tens in bits 7:4 and units in bits 3:0. `hour_out` uses the same encoding.
- R5: With `hr24`=0 the hours byte is 12-hour: bit 7 is the PM flag and bits 6:0 hold 1 to 12. Only 1 AM matches, and `hour_out` has bit 7 clear. With `hr24`=1 the hours byte is 0 to 23.
- R6: With `dst_en`=0 no command is issued.
- R7: With `inhibit`=1 no command is issued and the fall-back guard is not set.
- R8: Commands occur only in the cycle after a strobe and last exactly one cycle.
- R9: After reset both commands are low, `hour_out` is 0 and the guard is clear.
- R10: `hour_out` is 0 whenever no command is active, and the two commands never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | One-cycle strobe for the once-per-second update |
| inhibit | input | 1 | Update suspended (time being written) |
| dst_en | input | 1 | Daylight-saving correction enable |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour format, 0 = 12-hour format |
| sec_i | input | 8 | Seconds field |
| min_i | input | 8 | Minutes field |
| hour_i | input | 8 | Hours field |
| dow_i | input | 8 | Day of week, 1 = Sunday |
| date_i | input | 8 | Day of month |
| month_i | input | 8 | Month |
| jump_fwd | output | 1 | Spring-forward command pulse |
| fall_back | output | 1 | Autumn-back command pulse |
| hour_out | output | 8 | Replacement hours byte during a command |

## Verification
The assertions check the following on every cycle:
- A command only follows an enabled, uninhibited strobe.
- The two commands are exclusive and last one cycle each.
- The hour byte is zero when idle and equals 3 or 1 during the matching command.
- A fall-back is only issued while the guard was clear, and the guard is set afterwards.

Only the bench scenarios can show the following:
- The calendar windows at their edges (dates 7/8 and 24/25).
- The BCD-versus-binary decoding of months such as 0x10.
- The PM flag rejecting 1 PM.
- Re-arming of the guard once the day moves on.

// File: rtl/dst_pkg.sv
package dst_pkg;
  localparam int FW = 8;
  localparam int NF = 5;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DATE = 3;
  localparam int F_MON  = 4;

  function automatic logic [FW-1:0] to_plain(input logic [FW-1:0] v, input logic is_bin);
    logic [FW-1:0] tens;
    tens = {4'd0, v[7:4]};
    return is_bin ? v : (tens * 8'd10 + {4'd0, v[3:0]});
  endfunction

  function automatic logic [FW-1:0] to_coded(input logic [FW-1:0] v, input logic is_bin);
    logic [FW-1:0] t;
    logic [FW-1:0] u;
    t = v / 8'd10;
    u = v % 8'd10;
    return is_bin ? v : {t[3:0], u[3:0]};
  endfunction

  function automatic logic [FW-1:0] hour_byte(input logic [FW-1:0] v, input logic is_bin,
                                              input logic h24, input logic pm);
    logic [FW-1:0] c;
    c = to_coded(v, is_bin);
    return h24 ? c : {pm, c[6:0]};
  endfunction
endpackage

// File: rtl/dst_field_decode.sv
module dst_field_decode
  import dst_pkg::*;
(
  input  logic          bin_mode,
  input  logic          hr24,
  input  logic [FW-1:0] raw [NF],
  output logic [FW-1:0] val [NF],
  output logic          pm
);
  logic [FW-1:0] src [NF];

  always_comb begin
    for (int i = 0; i < NF; i++) src[i] = raw[i];
    if (!hr24) src[F_HR] = {1'b0, raw[F_HR][6:0]};
  end

  assign pm = !hr24 && raw[F_HR][7];

  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_dec
      assign val[g] = to_plain(src[g], bin_mode);
    end
  endgenerate
endmodule

// File: rtl/dst_rule_match.sv
module dst_rule_match
  import dst_pkg::*;
#(
  parameter int SUNDAY     = 1,
  parameter int SPRING_MON = 4,
  parameter int FALL_MON   = 10,
  parameter int FIRST_WK_END = 7,
  parameter int LAST_WK_BEG  = 25,
  parameter int MONTH_END    = 31,
  parameter int TRIG_HOUR    = 1
) (
  input  logic [FW-1:0] val [NF],
  input  logic          pm,
  input  logic [FW-1:0] dow,
  output logic          at_trigger,
  output logic          spring_day,
  output logic          fall_day
);
  localparam logic [FW-1:0] LAST_SEC = FW'(59);
  logic sunday;

  assign sunday = (dow == FW'(SUNDAY));
  assign at_trigger = (val[F_SEC] == LAST_SEC) && (val[F_MIN] == LAST_SEC) &&
                      (val[F_HR] == FW'(TRIG_HOUR)) && !pm;
  assign spring_day = sunday && (val[F_MON] == FW'(SPRING_MON)) &&
                      (val[F_DATE] >= FW'(1)) && (val[F_DATE] <= FW'(FIRST_WK_END));
  assign fall_day = sunday && (val[F_MON] == FW'(FALL_MON)) &&
                    (val[F_DATE] >= FW'(LAST_WK_BEG)) && (val[F_DATE] <= FW'(MONTH_END));
endmodule

// File: rtl/dst_once_guard.sv
module dst_once_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_day,
  input  logic fire_back,
  output logic done_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)          done_q <= 1'b0;
    else if (!fall_day)  done_q <= 1'b0;
    else if (fire_back)  done_q <= 1'b1;
  end
endmodule

// File: rtl/dst_adjuster.sv
module dst_adjuster
  import dst_pkg::*;
#(
  parameter int FWD_HOUR  = 3,
  parameter int BACK_HOUR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_stb,
  input  logic          inhibit,
  input  logic          dst_en,
  input  logic          bin_mode,
  input  logic          hr24,
  input  logic [FW-1:0] sec_i,
  input  logic [FW-1:0] min_i,
  input  logic [FW-1:0] hour_i,
  input  logic [FW-1:0] dow_i,
  input  logic [FW-1:0] date_i,
  input  logic [FW-1:0] month_i,
  output logic          jump_fwd,
  output logic          fall_back,
  output logic [FW-1:0] hour_out
);
  logic [FW-1:0] raw [NF];
  logic [FW-1:0] val [NF];
  logic pm, at_trigger, spring_day, fall_day, done_q;
  logic armed, fire_fwd, fire_back;

  assign raw[F_SEC]  = sec_i;
  assign raw[F_MIN]  = min_i;
  assign raw[F_HR]   = hour_i;
  assign raw[F_DATE] = date_i;
  assign raw[F_MON]  = month_i;

  dst_field_decode u_dec (
    .bin_mode(bin_mode), .hr24(hr24), .raw(raw), .val(val), .pm(pm)
  );

  dst_rule_match u_match (
    .val(val), .pm(pm), .dow(dow_i),
    .at_trigger(at_trigger), .spring_day(spring_day), .fall_day(fall_day)
  );

  assign armed     = upd_stb && !inhibit && dst_en && at_trigger;
  assign fire_fwd  = armed && spring_day;
  assign fire_back = armed && fall_day && !done_q;

  dst_once_guard u_guard (
    .clk(clk), .rst_n(rst_n), .fall_day(fall_day), .fire_back(fire_back), .done_q(done_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jump_fwd  <= 1'b0;
      fall_back <= 1'b0;
      hour_out  <= '0;
    end else begin
      jump_fwd  <= fire_fwd;
      fall_back <= fire_back;
      if (fire_fwd)       hour_out <= hour_byte(FW'(FWD_HOUR), bin_mode, hr24, 1'b0);
      else if (fire_back) hour_out <= hour_byte(FW'(BACK_HOUR), bin_mode, hr24, 1'b0);
      else                hour_out <= '0;
    end
  end
endmodule

// File: rtl/dst_adjuster_chk.sv
module dst_adjuster_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_stb,
  input logic       inhibit,
  input logic       dst_en,
  input logic       jump_fwd,
  input logic       fall_back,
  input logic [7:0] hour_out,
  input logic       fire_back,
  input logic       done_q
);
  p_cmd_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_fwd || fall_back) |-> $past(upd_stb && rst_n));
  p_cmd_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_fwd || fall_back) |-> $past(dst_en));
  p_cmd_not_inhibited_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_fwd || fall_back) |-> $past(!inhibit));
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(jump_fwd && fall_back));
  p_idle_hour_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(jump_fwd || fall_back) |-> hour_out == 8'h00);
  p_fwd_hour_r1: assert property (@(posedge clk) disable iff (!rst_n)
    jump_fwd |-> hour_out == 8'h03);
  p_back_hour_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_back |-> hour_out == 8'h01);
  p_back_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_back |-> ($past(!done_q) && done_q));
  p_fire_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !fire_back);
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_fwd || fall_back) |=> !(jump_fwd || fall_back));
endmodule

bind dst_adjuster dst_adjuster_chk u_chk (.*);

// File: tb/tb_dst_adjuster.sv
`timescale 1ns/1ps
module tb_dst_adjuster;
  logic clk = 1'b0;
  logic rst_n, upd_stb, inhibit, dst_en, bin_mode, hr24;
  logic [7:0] sec_i, min_i, hour_i, dow_i, date_i, month_i;
  logic jump_fwd, fall_back;
  logic [7:0] hour_out;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dst_adjuster dut (.*);

  // {bin, h24, sec, min, hour, dow, date, month, exp_fwd, exp_back, exp_hour}
  localparam int NV = 14;
  localparam logic [59:0] VEC [NV] = '{
    {1'b0,1'b1,8'h59,8'h59,8'h01,8'd1,8'h01,8'h04,1'b1,1'b0,8'h03}, // R1 R4 BCD 24h
    {1'b1,1'b1,8'd59,8'd59,8'd1, 8'd1,8'd7, 8'd4, 1'b1,1'b0,8'h03}, // R1 R4 bin date 7
    {1'b0,1'b0,8'h59,8'h59,8'h01,8'd1,8'h07,8'h04,1'b1,1'b0,8'h03}, // R5 12h AM
    {1'b0,1'b0,8'h59,8'h59,8'h81,8'd1,8'h07,8'h04,1'b0,1'b0,8'h00}, // R5 1 PM
    {1'b1,1'b1,8'd59,8'd59,8'd1, 8'd1,8'd8, 8'd4, 1'b0,1'b0,8'h00}, // R1 date 8
    {1'b1,1'b1,8'd59,8'd59,8'd1, 8'd2,8'd3, 8'd4, 1'b0,1'b0,8'h00}, // R1 Monday
    {1'b0,1'b1,8'h59,8'h59,8'h01,8'd1,8'h25,8'h10,1'b0,1'b1,8'h01}, // R2 R4 BCD Oct 25
    {1'b1,1'b1,8'd59,8'd59,8'd1, 8'd1,8'd31,8'd10,1'b0,1'b1,8'h01}, // R2 bin Oct 31
    {1'b1,1'b1,8'd59,8'd59,8'd1, 8'd1,8'd24,8'd10,1'b0,1'b0,8'h00}, // R2 date 24
    {1'b0,1'b1,8'h58,8'h59,8'h01,8'd1,8'h25,8'h10,1'b0,1'b0,8'h00}, // R2 second 58
    {1'b1,1'b1,8'd59,8'd59,8'd1, 8'd1,8'd25,8'h10,1'b0,1'b0,8'h00}, // R4 0x10 is 16 in bin
    {1'b0,1'b0,8'h59,8'h59,8'h01,8'd1,8'h31,8'h10,1'b0,1'b1,8'h01}, // R5 12h Oct AM
    {1'b0,1'b0,8'h59,8'h59,8'h81,8'd1,8'h31,8'h10,1'b0,1'b0,8'h00}, // R5 12h Oct PM
    {1'b1,1'b1,8'd59,8'd59,8'd2, 8'd1,8'd25,8'd10,1'b0,1'b0,8'h00}  // R2 hour 2
  };

  task automatic check(input logic fw, input logic bk, input logic [7:0] hr,
                       input logic efw, input logic ebk, input logic [7:0] ehr,
                       input string req);
    n_chk++;
    if (fw !== efw || bk !== ebk || hr !== ehr) begin
      n_bad++;
      $display("FAIL %s: fwd/back/hour = %b/%b/%h expected %b/%b/%h",
               req, fw, bk, hr, efw, ebk, ehr);
    end
  endtask

  task automatic set_time(input logic b, input logic h, input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] hr, input logic [7:0] dw, input logic [7:0] dt,
                          input logic [7:0] mo);
    bin_mode = b; hr24 = h; sec_i = s; min_i = m; hour_i = hr;
    dow_i = dw; date_i = dt; month_i = mo;
  endtask

  // strobe for one cycle, then sample the registered result
  task automatic pulse_and_check(input logic efw, input logic ebk, input logic [7:0] ehr,
                                 input string req);
    @(negedge clk); upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
    check(jump_fwd, fall_back, hour_out, efw, ebk, ehr, req);
  endtask

  task automatic leave_day();
    @(negedge clk);
    set_time(1'b1, 1'b1, 8'd0, 8'd0, 8'd5, 8'd3, 8'd2, 8'd1);
    @(negedge clk);
  endtask

  initial begin
    #(4ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd_stb = 1'b0; inhibit = 1'b0; dst_en = 1'b1;
    set_time(1'b1, 1'b1, 8'd0, 8'd0, 8'd0, 8'd3, 8'd2, 8'd1);
    repeat (3) @(negedge clk);
    check(jump_fwd, fall_back, hour_out, 1'b0, 1'b0, 8'h00, "R9 reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      leave_day();
      set_time(VEC[i][59], VEC[i][58], VEC[i][57:50], VEC[i][49:42], VEC[i][41:34],
               VEC[i][33:26], VEC[i][25:18], VEC[i][17:10]);
      pulse_and_check(VEC[i][9], VEC[i][8], VEC[i][7:0], $sformatf("R1/R2/R4/R5 vec %0d", i));
    end

    // R8: pulse lasts one cycle, and no strobe means no command
    leave_day();
    set_time(1'b1, 1'b1, 8'd59, 8'd59, 8'd1, 8'd1, 8'd3, 8'd4);
    pulse_and_check(1'b1, 1'b0, 8'h03, "R1 spring");
    @(negedge clk);
    check(jump_fwd, fall_back, hour_out, 1'b0, 1'b0, 8'h00, "R8 one-cycle pulse");
    repeat (2) @(negedge clk);
    check(jump_fwd, fall_back, hour_out, 1'b0, 1'b0, 8'h00, "R8 no strobe");

    // R3: second pass on the repeated hour is not corrected
    leave_day();
    set_time(1'b1, 1'b1, 8'd59, 8'd59, 8'd1, 8'd1, 8'd28, 8'd10);
    pulse_and_check(1'b0, 1'b1, 8'h01, "R3 first pass");
    pulse_and_check(1'b0, 1'b0, 8'h00, "R3 second pass");
    leave_day();
    set_time(1'b1, 1'b1, 8'd59, 8'd59, 8'd1, 8'd1, 8'd28, 8'd10);
    pulse_and_check(1'b0, 1'b1, 8'h01, "R3 re-armed");

    // R6: enable off
    leave_day();
    dst_en = 1'b0;
    set_time(1'b1, 1'b1, 8'd59, 8'd59, 8'd1, 8'd1, 8'd28, 8'd10);
    pulse_and_check(1'b0, 1'b0, 8'h00, "R6 disabled");
    dst_en = 1'b1;

    // R7: inhibit blocks, and does not consume the one shot
    inhibit = 1'b1;
    pulse_and_check(1'b0, 1'b0, 8'h00, "R7 inhibited");
    inhibit = 1'b0;
    pulse_and_check(1'b0, 1'b1, 8'h01, "R7 guard untouched");

    // R9: reset clears the guard
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(jump_fwd, fall_back, hour_out, 1'b0, 1'b0, 8'h00, "R9 in reset");
    rst_n = 1'b1;
    pulse_and_check(1'b0, 1'b1, 8'h01, "R9 guard cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule